// File: doc/BRIEF.md
# Read-Data Sampling Delay Trainer

This block chooses the sampling delay for a serial read-data input. It tries each value of a 2-bit delay setting, from 0 up to 3. The settings correspond to 0, 2, 4 and 6 ns. At every setting the block issues one read of a fixed test register through a simple request/response channel and compares the returned word with a known pattern. Each setting that returns the pattern sets its own bit in a 4-bit pass mask. When the last trial is done, a fixed table turns the mask into the delay that is kept for normal operation. If the passing settings do not form a usable window, the block flags an error and keeps the delay it had before the sweep.

A start pulse launches a sweep. While the sweep runs, `dly_sel_o` drives the delay element with the setting under trial. After the sweep it holds the chosen operating value. A trial read that gets no answer within a bounded number of cycles counts as a miss.

Top module: `rxd_delay_cal`

## Requirements
- R1: A sweep tries the settings in the order 0, 1, 2, 3. During each trial `dly_sel_o` equals the trial index and `rd_addr_o` equals 0xBC0A while `rd_req_o` is high.
- R2: `rd_req_o` stays high through the whole sweep. The trial setting changes only in the cycle after the current read has been answered or has timed out.
- R3: If a response returns `rd_data_i` equal to 0x5AA5, mask bit i is set for trial i. Any other value leaves bit i clear.
- R4: A trial with no response for TMO_CYC cycles (32 by default) is counted as a miss, and the sweep moves on.
- R5: The mask (bit i = setting i passed) maps to a setting as follows: 1→0, 2→1, 3→0, 4→2, 6→1, 7→1, 8→3, 12→3, 14→2, 15→1. On a match, `dly_sel_o` holds that value after the sweep.
- R6: Masks 0, 5, 9, 10, 11 and 13 are failures. In that case `err_o` goes high and `dly_sel_o` returns to the operating value it had before the sweep.
- R7: `done_o` is high for exactly one cycle, the cycle after the last trial closes. `err_o` changes in that same cycle and stays valid until the next accepted start.
- R8: A `start_i` pulse during a sweep has no effect: the trial in progress, its setting and the final result are unchanged.
- R9: After reset, `dly_sel_o` is 0 and `rd_req_o`, `done_o` and `err_o` are low.
- R10: `rd_vld_i` outside a sweep is ignored. The outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a sweep (one-cycle pulse) |
| rd_req_o | output | 1 | Trial read request, held while a sweep runs |
| rd_addr_o | output | ADDR_W | Test register address |
| rd_vld_i | input | 1 | Read response valid |
| rd_data_i | input | DATA_W | Read response data |
| dly_sel_o | output | 2 | Delay setting: trial value during a sweep, operating value otherwise |
| done_o | output | 1 | Sweep finished, one-cycle pulse |
| err_o | output | 1 | Last sweep produced a failing mask |

## Verification
The hardest conditions to reach from the ports are a failing mask that follows a successful sweep, and a timeout that lands on the last trial. Only in the first case can the bench see that the operating delay is kept, and only in the second does a miss close the sweep. The bench answers every trial read itself, so it decides per trial between a match, a corrupted word and silence. Directed sweeps build the non-contiguous masks and the timeout masks. Seeded random sweeps then mix outcomes and response latencies, include a start pulse mid-sweep, and compare each result with a bench table built from R5 and R6.

// File: rtl/rxd_cal_pkg.sv
package rxd_cal_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} cal_state_e;

  typedef struct packed {
    logic       ok;
    logic [1:0] sel;
  } pick_t;

  // pass mask -> operating setting; ok=0 marks a rejected window
  function automatic pick_t pick_from_mask(input logic [3:0] m);
    pick_t p;
    p.ok  = 1'b1;
    p.sel = 2'd0;
    case (m)
      4'd1, 4'd3:        p.sel = 2'd0;
      4'd2, 4'd6, 4'd7,
      4'd15:             p.sel = 2'd1;
      4'd4, 4'd14:       p.sel = 2'd2;
      4'd8, 4'd12:       p.sel = 2'd3;
      default:           p.ok  = 1'b0;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/rxd_trial_timer.sv
module rxd_trial_timer #(
  parameter int TMO_CYC = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic expire_o
);
  localparam int CNT_W = (TMO_CYC > 2) ? $clog2(TMO_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || clr_i)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == CNT_LAST);

  // R4: an expiry closes the trial, so the next trial starts from zero
  p_expire_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (cnt_q == '0));
endmodule

// File: rtl/rxd_mask_decode.sv
module rxd_mask_decode
  import rxd_cal_pkg::*;
(
  input  logic [3:0] mask_i,
  output logic       ok_o,
  output logic [1:0] sel_o
);
  pick_t pick;

  always_comb begin
    pick  = pick_from_mask(mask_i);
    ok_o  = pick.ok;
    sel_o = pick.sel;
  end

  // R5: a chosen setting must itself have passed
  always_comb begin
    p_pick_passed_r5: assert (!ok_o || mask_i[sel_o]);
  end
endmodule

// File: rtl/rxd_delay_cal.sv
module rxd_delay_cal
  import rxd_cal_pkg::*;
#(
  parameter int               ADDR_W    = 16,
  parameter int               DATA_W    = 16,
  parameter logic [ADDR_W-1:0] TEST_ADDR = 16'hBC0A,
  parameter logic [DATA_W-1:0] TEST_PAT  = 16'h5AA5,
  parameter int               TMO_CYC   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_vld_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [1:0]        dly_sel_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int DLY_W   = 2;
  localparam int N_TRIAL = 1 << DLY_W;
  localparam logic [DLY_W-1:0] LAST_IDX = DLY_W'(N_TRIAL - 1);

  cal_state_e          state_q;
  logic [DLY_W-1:0]    idx_q, op_sel_q;
  logic [N_TRIAL-1:0]  mask_q, mask_nx;
  logic                done_q, err_q;
  logic                run, hit, expire, close, last;
  logic                dec_ok;
  logic [DLY_W-1:0]    dec_sel;

  assign run   = (state_q == ST_RUN);
  assign hit   = rd_vld_i && (rd_data_i == TEST_PAT);
  assign close = run && (rd_vld_i || expire);
  assign last  = (idx_q == LAST_IDX);

  rxd_trial_timer #(.TMO_CYC(TMO_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .clr_i    (close),
    .expire_o (expire)
  );

  // mask including the trial closing this cycle
  always_comb begin
    mask_nx = mask_q;
    if (close) mask_nx[idx_q] = hit;
  end

  rxd_mask_decode u_dec (
    .mask_i (mask_nx),
    .ok_o   (dec_ok),
    .sel_o  (dec_sel)
  );

  for (genvar g = 0; g < N_TRIAL; g++) begin : g_mask
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      mask_q[g] <= 1'b0;
      else if (!run && start_i)         mask_q[g] <= 1'b0;
      else if (close && idx_q == DLY_W'(g)) mask_q[g] <= hit;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      op_sel_q <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          idx_q   <= '0;
          err_q   <= 1'b0;
        end
        ST_RUN: if (close) begin
          if (last) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            if (dec_ok) op_sel_q <= dec_sel;
            else        err_q    <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_o  = run;
  assign rd_addr_o = TEST_ADDR;
  assign dly_sel_o = run ? idx_q : op_sel_q;
  assign done_o    = done_q;
  assign err_o     = err_q;

  // R1: each sweep opens on setting 0
  p_sweep_opens_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_req_o) |-> (dly_sel_o == '0));
  // R2: setting held while the read is outstanding
  p_trial_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_vld_i && !expire) |=> (rd_req_o && $stable(dly_sel_o)));
  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7: error only rises at sweep end and holds until a start
  p_err_at_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o);
  p_err_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !start_i) |=> err_o);
  // R8: start during a non-final trial does not end the sweep
  p_start_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && start_i && dly_sel_o != LAST_IDX) |=> rd_req_o);
endmodule

// File: tb/rxd_delay_cal_bench.sv
`timescale 1ns/1ps
module rxd_delay_cal_bench;
  localparam int TMO = 32;
  localparam logic [15:0] PAT  = 16'h5AA5;
  localparam logic [15:0] ADDR = 16'hBC0A;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, rd_vld_i = 1'b0;
  logic [15:0] rd_data_i = '0;
  logic rd_req_o, done_o, err_o;
  logic [15:0] rd_addr_o;
  logic [1:0] dly_sel_o;

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  logic [1:0] exp_sel = 2'd0;

  always #2 clk = ~clk;

  rxd_delay_cal u_rxd_delay_cal (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_vld_i(rd_vld_i), .rd_data_i(rd_data_i),
    .dly_sel_o(dly_sel_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // table from R5/R6; returns -1 for rejected masks
  function automatic int ref_pick(input logic [3:0] m);
    case (m)
      4'd1: return 0;  4'd2: return 1;  4'd3: return 0;  4'd4: return 2;
      4'd6: return 1;  4'd7: return 1;  4'd8: return 3;  4'd12: return 3;
      4'd14: return 2; 4'd15: return 1;
      default: return -1;
    endcase
  endfunction

  task automatic run_sweep(input logic [3:0] pass, input logic [3:0] tmo, input bit midstart);
    logic [3:0] m;
    int pk;
    m  = pass & ~tmo;
    pk = ref_pick(m);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      // R1: trial order and address
      chk(rd_req_o && dly_sel_o == 2'(k) && rd_addr_o == ADDR, "R1 trial", dly_sel_o, k);
      if (tmo[k]) begin
        int n = 0;
        while (rd_req_o && dly_sel_o == 2'(k) && n < 200) begin
          @(negedge clk); n++;
        end
        chk(n == TMO, "R4 timeout length", n, TMO); // R4
      end else begin
        int lat = $urandom % 4;
        if (midstart && k == 1) begin
          start_i = 1'b1; @(negedge clk); start_i = 1'b0;
          chk(rd_req_o && dly_sel_o == 2'd1, "R8 start ignored", dly_sel_o, 1); // R8
        end
        repeat (lat) @(negedge clk);
        chk(rd_req_o && dly_sel_o == 2'(k), "R2 hold while waiting", dly_sel_o, k); // R2
        rd_vld_i  = 1'b1;
        rd_data_i = pass[k] ? PAT : (PAT ^ (16'($urandom) | 16'h0001)); // R3
        @(negedge clk);
        rd_vld_i  = 1'b0;
      end
    end
    if (pk >= 0) exp_sel = 2'(pk);
    chk(done_o == 1'b1, "R7 done pulse", done_o, 1);
    chk(err_o == (pk < 0), "R6 err flag", err_o, pk < 0);
    chk(dly_sel_o == exp_sel, "R5 chosen setting", dly_sel_o, exp_sel);
    chk(!rd_req_o, "R2 request dropped", rd_req_o, 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R7 done one cycle", done_o, 0);
    chk(err_o == (pk < 0), "R7 err held", err_o, pk < 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd17));
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(dly_sel_o == 0 && !rd_req_o && !done_o && !err_o, "R9 reset", {dly_sel_o, rd_req_o, done_o, err_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    run_sweep(4'hF, 4'h0, 0);   // -> 1
    run_sweep(4'h8, 4'h0, 0);   // -> 3
    run_sweep(4'h5, 4'h0, 0);   // R6 non-contiguous, keep 3
    run_sweep(4'h0, 4'h0, 0);   // R6 all mismatch
    run_sweep(4'hC, 4'h0, 1);   // R8 mid-sweep start, -> 3
    run_sweep(4'hF, 4'hF, 0);   // R4 all timeouts -> error
    run_sweep(4'h7, 4'h8, 0);   // R4 last-trial timeout -> 1
    run_sweep(4'hE, 4'h1, 0);   // -> 2
    // R10: response outside sweep ignored
    @(negedge clk); rd_vld_i = 1'b1; rd_data_i = PAT;
    repeat (2) @(negedge clk);
    chk(!rd_req_o && !done_o && dly_sel_o == exp_sel, "R10 idle response", dly_sel_o, exp_sel);
    rd_vld_i = 1'b0;
    for (int i = 0; i < 24; i++) begin
      logic [3:0] p, t;
      p = 4'($urandom);
      t = ($urandom % 6 == 0) ? 4'(1 << ($urandom % 4)) : 4'h0;
      run_sweep(p, t, ($urandom % 4) == 0);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule